// File: doc/BRIEF.md
# Multi-cycle wide adder

This block adds two 64-bit operands on a datapath narrower than the operands. It handles one slice per clock cycle. The first slice is the least-significant one. The carry out of each slice goes into a flip-flop and becomes the carry in of the next slice. The slice width is a parameter. A 32-bit slice gives two steps per full add, and a 16-bit slice gives four steps, which suits small devices.

The add can finish early. Once every slice above the current one is zero in both operands, no further slice can add anything except the pending carry. The block then stops at that point, so latency depends on the data.

A caller pulses `start_i` together with the operands while the block is idle. It waits for `done_o`, then reads `sum_o` and `cout_o`. Those outputs hold their values until the next add is accepted.

Top module: `mcw_wide_adder`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `done_o`, `cout_o` and `sum_o` are all zero.
- R2: A start sampled while `busy_o` is low is accepted. `busy_o` is high from the next cycle until the cycle in which `done_o` is high.
- R3: When `done_o` is high, `{cout_o, sum_o}` equals the 65-bit sum of the two accepted operands.
- R4: Slices are added from least to most significant. The carry out of each slice is registered and fed into the next slice, so a carry ripples across every slice boundary (for example, all-ones plus one gives `sum_o` zero and `cout_o` one).
- R5: `done_o` rises k cycles after the accepting edge. Here k is the index of the highest slice in which either operand is nonzero, plus one, and k is at least 1. A full add therefore takes 64/SLICE_W cycles.
- R6: On an early finish, the result slice just above the last processed slice holds the pending carry zero-extended. All higher result bits are zero and `cout_o` is zero.
- R7: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R8: A start that arrives while `busy_o` is high is ignored. The running add completes with its original operands and latency, and no second add follows.
- R9: While the block is idle and no start is given, `sum_o` and `cout_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a new add, with operands on `a_i`/`b_i` |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| busy_o | output | 1 | An add is in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| sum_o | output | 64 | Sum, held until the next accepted start |
| cout_o | output | 1 | Carry out of bit 63 |

## Verification
The bench runs with 16-bit slices. Operands are drawn at random over all 64 bits, and also with their top 16, 32 or 48 bits cleared. The full-width draws exercise the four-step path. The cleared-top draws separate each early-finish depth, because the measured latency must match the highest nonzero slice. Directed carry cases cover two situations. In the first, a carry crosses every boundary, such as all-ones plus one. In the second, a carry spills into an otherwise empty upper slice. Together they separate a correct registered carry from a dropped carry, and a correct early-finish fill from a zeroed upper slice. Further directed sequences do three things: they poke start while busy, idle between operations, and issue operations back to back.

// File: rtl/mcw_add_pkg.sv
package mcw_add_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } add_state_e;
endpackage

// File: rtl/mcw_slice_adder.sv
module mcw_slice_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/mcw_zero_scan.sv
// Flags that every slice above idx_i is zero in both operands.
module mcw_zero_scan #(
  parameter int unsigned N     = 2,
  parameter int unsigned W     = 32,
  parameter int unsigned IDX_W = 1
) (
  input  logic [N*W-1:0] op_a_i,
  input  logic [N*W-1:0] op_b_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic           upper_zero_o
);
  logic [N-1:0] nz;

  for (genvar s = 0; s < N; s++) begin : g_nz
    assign nz[s] = |(op_a_i[s*W +: W] | op_b_i[s*W +: W]);
  end

  always_comb begin
    upper_zero_o = 1'b1;
    for (int s = 0; s < N; s++) begin
      if ((s > int'(idx_i)) && nz[s]) upper_zero_o = 1'b0;
    end
  end
endmodule

// File: rtl/mcw_add_ctrl.sv
module mcw_add_ctrl
  import mcw_add_pkg::*;
#(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             upper_zero_i,
  input  logic             slice_cout_i,
  output logic             accept_o,
  output logic             step_o,
  output logic             finish_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             carry_o,
  output logic             busy_o
);
  add_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             carry_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign step_o   = (state_q == ST_RUN);
  assign last_o   = (idx_q == IDX_W'(N - 1));
  assign finish_o = step_o && (last_o || upper_zero_i);
  assign idx_o    = idx_q;
  assign carry_o  = carry_q;
  assign busy_o   = step_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      carry_q <= 1'b0;
    end else if (accept_o) begin
      state_q <= ST_RUN;
      idx_q   <= '0;
      carry_q <= 1'b0;
    end else if (step_o) begin
      carry_q <= slice_cout_i;
      idx_q   <= idx_q + 1'b1;
      if (finish_o) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/mcw_wide_adder.sv
module mcw_wide_adder #(
  parameter int unsigned OP_W    = 64,
  parameter int unsigned SLICE_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [OP_W-1:0] sum_o,
  output logic            cout_o
);
  localparam int unsigned N_SLICE = OP_W / SLICE_W;
  localparam int unsigned IDX_W   = (N_SLICE > 1) ? $clog2(N_SLICE) : 1;

  logic [OP_W-1:0]    op_a_q, op_b_q;
  logic [SLICE_W-1:0] res_q [N_SLICE];
  logic               cout_q, done_q;

  logic               accept, step, finish, last, carry, upper_zero;
  logic [IDX_W-1:0]   idx;
  logic [SLICE_W-1:0] sl_a, sl_b, sl_sum;
  logic               sl_cout;

  assign sl_a = op_a_q[idx*SLICE_W +: SLICE_W];
  assign sl_b = op_b_q[idx*SLICE_W +: SLICE_W];

  mcw_slice_adder #(.W(SLICE_W)) u_slice (
    .a_i   (sl_a),
    .b_i   (sl_b),
    .cin_i (carry),
    .sum_o (sl_sum),
    .cout_o(sl_cout)
  );

  mcw_zero_scan #(.N(N_SLICE), .W(SLICE_W), .IDX_W(IDX_W)) u_scan (
    .op_a_i      (op_a_q),
    .op_b_i      (op_b_q),
    .idx_i       (idx),
    .upper_zero_o(upper_zero)
  );

  mcw_add_ctrl #(.N(N_SLICE), .IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .upper_zero_i(upper_zero),
    .slice_cout_i(sl_cout),
    .accept_o    (accept),
    .step_o      (step),
    .finish_o    (finish),
    .last_o      (last),
    .idx_o       (idx),
    .carry_o     (carry),
    .busy_o      (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_a_q <= '0;
      op_b_q <= '0;
    end else if (accept) begin
      op_a_q <= a_i;
      op_b_q <= b_i;
    end
  end

  for (genvar s = 0; s < N_SLICE; s++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_q[s] <= '0;
      end else if (accept) begin
        res_q[s] <= '0;
      end else if (step && idx == IDX_W'(s)) begin
        res_q[s] <= sl_sum;
      end else if ((s != 0) && finish && !last && idx == IDX_W'(s - 1)) begin
        // early finish: pending carry lands just above the last slice
        res_q[s] <= SLICE_W'(sl_cout);
      end
    end
    assign sum_o[s*SLICE_W +: SLICE_W] = res_q[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cout_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept)      cout_q <= 1'b0;
      else if (finish) cout_q <= last ? sl_cout : 1'b0;
    end
  end

  assign done_o = done_q;
  assign cout_o = cout_q;
endmodule

// File: rtl/mcw_add_chk.sv
module mcw_add_chk #(
  parameter int unsigned OP_W    = 64,
  parameter int unsigned SLICE_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [OP_W-1:0] a_i,
  input logic [OP_W-1:0] b_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [OP_W-1:0] sum_o,
  input logic            cout_o
);
  localparam int unsigned N_SLICE = OP_W / SLICE_W;

  logic [OP_W:0] ref_q;
  int unsigned   busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q    <= '0;
      busy_cnt <= 0;
    end else if (start_i && !busy_o) begin
      ref_q    <= {1'b0, a_i} + {1'b0, b_i};
      busy_cnt <= 1;
    end else if (busy_o) begin
      busy_cnt <= busy_cnt + 1;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i) !rst_ni |=> (!busy_o && !done_o));
  p_busy_after_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_busy_ends_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o ##1 !busy_o) |-> done_o);
  p_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({cout_o, sum_o} == ref_q));
  p_latency_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt <= N_SLICE));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(sum_o) && $stable(cout_o)));
endmodule

bind mcw_wide_adder mcw_add_chk #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .sum_o  (sum_o),
  .cout_o (cout_o)
);

// File: tb/mcw_wide_adder_test.sv
module mcw_wide_adder_test;
  localparam int OP_W = 64;
  localparam int SW   = 16;
  localparam int NS   = OP_W / SW;

  typedef struct {
    logic [OP_W-1:0] sum;
    logic            cout;
    int              lat;
    int              acc;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [OP_W-1:0] a_i = '0, b_i = '0;
  logic            busy_o, done_o, cout_o;
  logic [OP_W-1:0] sum_o;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  exp_t q[$];
  logic [OP_W-1:0] last_sum = '0;
  logic            last_cout = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mcw_wide_adder #(.OP_W(OP_W), .SLICE_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o), .cout_o(cout_o)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  function automatic int exp_lat(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    int k = 1;
    for (int s = 0; s < NS; s++)
      if (|(a[s*SW +: SW] | b[s*SW +: SW])) k = s + 1;
    return k;
  endfunction

  task automatic send(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input string tag);
    exp_t e;
    logic [OP_W:0] full;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    start_i = 1'b1; a_i = a; b_i = b;
    full  = {1'b0, a} + {1'b0, b};
    e.sum = full[OP_W-1:0]; e.cout = full[OP_W];
    e.lat = exp_lat(a, b); e.acc = cyc + 1; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", $sformatf("unexpected done, sum %h expected none", sum_o));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(sum_o == e.sum && cout_o == e.cout, e.tag,
              $sformatf("result %b_%h expected %b_%h", cout_o, sum_o, e.cout, e.sum));
        check(cyc - e.acc == e.lat, "R5",
              $sformatf("latency %0d expected %0d (%s)", cyc - e.acc, e.lat, e.tag));
        last_sum = e.sum; last_cout = e.cout;
      end
    end
  end

  // R7: done one cycle, busy low with it
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o && done_prev)
        check(1'b0, "R7", "done high 2 cycles, expected 1");
      if (done_o && busy_o)
        check(1'b0, "R7", "busy 1 with done, expected 0");
    end
    done_prev = done_o;
  end

  task automatic rand_op(input int keep, input string tag);
    logic [OP_W-1:0] a, b, m;
    a = {$urandom, $urandom}; b = {$urandom, $urandom};
    m = (keep >= OP_W) ? '1 : ((64'd1 << keep) - 1);
    send(a & m, b & m, tag);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && sum_o == 0 && cout_o == 0, "R1",
          $sformatf("reset busy %b done %b sum %h cout %b expected 0", busy_o, done_o, sum_o, cout_o));
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R1", $sformatf("after reset busy %b done %b expected 0", busy_o, done_o));

    // R2: busy in cycle after accept
    send(64'h1234_5678_9abc_def0, 64'h1111_2222_3333_4444, "R2");
    check(busy_o == 1, "R2", $sformatf("busy %b expected 1", busy_o));
    drain();

    // R4: carry through every slice
    send('1, 64'd1, "R4");
    drain();
    send(64'h0000_FFFF_FFFF_FFFF, 64'd1, "R4");
    drain();

    // R6: early finish with carry spill
    send(64'h0000_0000_0000_FFFF, 64'd1, "R6");
    drain();
    check(sum_o == 64'h1_0000 && cout_o == 0, "R6", $sformatf("sum %h expected 10000", sum_o));
    send(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, "R6");
    drain();
    send(64'd0, 64'd0, "R6");
    drain();

    // R8: start while busy ignored
    send('1, 64'd3, "R8");
    start_i = 1'b1; a_i = 64'd5; b_i = 64'd7;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    check(busy_o == 0 && sum_o == 64'd2 && cout_o == 1, "R8",
          $sformatf("busy %b sum %h expected 0/2", busy_o, sum_o));
    send(64'd5, 64'd0, "R8");   // short op: poke lands on its only busy cycle
    start_i = 1'b1; a_i = '1; b_i = '1;
    @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (4) @(negedge clk);
    check(sum_o == 64'd5 && busy_o == 0, "R8", $sformatf("sum %h expected 5", sum_o));

    // R3/R5: random, full and cleared tops, back to back
    for (int i = 0; i < 40; i++) begin
      rand_op(64, "R3");
      rand_op(48, "R5");
      rand_op(32, "R5");
      rand_op(16, "R5");
    end
    drain();

    // R9: hold while idle
    repeat (6) @(negedge clk);
    check(sum_o == last_sum && cout_o == last_cout, "R9",
          $sformatf("held %b_%h expected %b_%h", cout_o, sum_o, last_cout, last_sum));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule